// File: doc/BRIEF.md
# Bus-Width Matching Converter

This block adapts a narrow external port to an 80-bit internal word path. Its packing half gathers narrow transfers into one full 80-bit word. Its unpacking half splits each 80-bit word into a run of narrow transfers. Each half has its own width setting, and the port width can be 80, 40, 20 or 10 bits, which gives 1, 2, 4 or 8 pieces per word. The unpacking half sends the pieces of a word in either little-endian or big-endian order.

Every interface is a valid/ready handshake. The two width settings and the order select are captured only while reset is held. A typical use places the packer in front of a word-wide storage array and the unpacker behind it. The test bench loops the packer's word output straight into the unpacker.

Top module: `bm_bus_match`

## Requirements
- R1: A width code of 2'b00 selects 80-bit pieces, 2'b01 selects 40-bit pieces, 2'b10 selects 20-bit pieces and 2'b11 selects 10-bit pieces. The code sets 1, 2, 4 or 8 pieces per word on that side.
- R2: The packer writes its first accepted piece into word bits [w-1:0], where w is the piece width, and writes each later piece into the next w bits above. Input bits above w are ignored.
- R3: The packer presents a word only after it has accepted the full number of pieces. It never emits a partial word.
- R4: Every unpacked piece appears on the low w bits of `out_data`, and all bits above w read as zero.
- R5: When the order select captured at reset is 0 (little-endian), the unpacker sends the least significant piece of the word first.
- R6: When the order select captured at reset is 1 (big-endian), the unpacker sends the most significant piece of the word first.
- R7: Both width codes and the order select are sampled only while reset is asserted. Changes to them after reset have no effect.
- R8: A reset that arrives partway through a word throws away the partly packed or partly unpacked word, and both halves start again at the first piece.
- R9: While a handshake is stalled, the valid signal and its data stay stable. The packer drops `in_ready` while it holds a word that is not yet taken. The unpacker drops `word_in_ready` while pieces of its current word are stalled.
- R10: After reset, `word_valid` and `out_valid` are low and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in_size | input | 2 | Packer width code, sampled in reset |
| cfg_out_size | input | 2 | Unpacker width code, sampled in reset |
| cfg_big_endian | input | 1 | Unpacker piece order, 1 = most significant piece first, sampled in reset |
| in_valid | input | 1 | Narrow input piece valid |
| in_data | input | 80 | Narrow input piece, on the low bits |
| in_ready | output | 1 | Packer accepts a piece |
| word_valid | output | 1 | Packed word valid |
| word_data | output | 80 | Packed word |
| word_ready | input | 1 | Downstream takes the packed word |
| word_in_valid | input | 1 | Word to unpack is valid |
| word_in_data | input | 80 | Word to unpack |
| word_in_ready | output | 1 | Unpacker accepts a word |
| out_valid | output | 1 | Narrow output piece valid |
| out_data | output | 80 | Narrow output piece, upper bits zero |
| out_ready | input | 1 | Downstream takes the piece |

## Verification
The bench builds the block with its default 80-bit word. At that size every width code is a clean divisor, and the 8-piece case uses a 3-bit piece index at full range.

With the packer looped into the unpacker, each table row exercises a different pairing of input width, output width and piece order. The exact piece sequence can then be predicted from the word alone.

Directed cases cover three situations:
- reset arriving mid-word on each side,
- configuration inputs that move after reset,
- a downstream stall long enough to back up into the packer.

// File: rtl/bm_pkg.sv
package bm_pkg;

  // Width code: selects pieces per word as 1 << code
  typedef enum logic [1:0] {
    SZ_FULL    = 2'b00,
    SZ_HALF    = 2'b01,
    SZ_QUARTER = 2'b10,
    SZ_EIGHTH  = 2'b11
  } bm_size_e;

  localparam int unsigned MAX_PIECES = 8;
  localparam int unsigned CNT_W      = $clog2(MAX_PIECES);

  function automatic int unsigned piece_width(input int unsigned word_w, input logic [1:0] code);
    return word_w >> code;
  endfunction

  function automatic logic [CNT_W-1:0] last_index(input logic [1:0] code);
    return CNT_W'((32'd1 << code) - 32'd1);
  endfunction

endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sync_q[STAGES-1];

endmodule

// File: rtl/bm_packer.sv
module bm_packer
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              w_valid,
  output logic [WORD_W-1:0] w_data,
  input  logic              w_ready
);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic              full_q, full_d;
  logic              accept, at_last;
  logic [WORD_W-1:0] mask;
  int unsigned       width, shift;

  always_comb begin
    width    = piece_width(WORD_W, sel);
    mask     = {WORD_W{1'b1}} >> (WORD_W - width);
    shift    = 32'(idx_q) * width;
    at_last  = (idx_q == last_index(sel));
    in_ready = !full_q || w_ready;
    accept   = in_valid && in_ready;

    acc_d  = (acc_q & ~(mask << shift)) | ((in_data & mask) << shift);
    idx_d  = idx_q;
    full_d = full_q;
    if (full_q && w_ready) full_d = 1'b0;
    if (accept) begin
      if (at_last) begin
        idx_d  = '0;
        full_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (accept) begin
        acc_q <= acc_d;
        idx_q <= idx_d;
      end
      full_q <= full_d;
    end
  end

  assign w_valid = full_q;
  assign w_data  = acc_q;

endmodule

// File: rtl/bm_unpacker.sv
module bm_unpacker
  import bm_pkg::*;
#(
  parameter int unsigned WORD_W = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              big,
  input  logic              w_valid,
  input  logic [WORD_W-1:0] w_data,
  output logic              w_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready
);

  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  idx_q, idx_d, slot;
  logic              busy_q, busy_d;
  logic              pop, load, at_last;
  logic [WORD_W-1:0] mask;
  int unsigned       width, pos;

  always_comb begin
    width   = piece_width(WORD_W, sel);
    mask    = {WORD_W{1'b1}} >> (WORD_W - width);
    at_last = (idx_q == last_index(sel));
    slot    = big ? (last_index(sel) - idx_q) : idx_q;
    pos     = 32'(slot) * width;
    pop     = busy_q && out_ready;
    w_ready = !busy_q || (pop && at_last);
    load    = w_valid && w_ready;

    busy_d = busy_q;
    idx_d  = idx_q;
    if (pop) begin
      idx_d = at_last ? '0 : idx_q + 1'b1;
      if (at_last) busy_d = 1'b0;
    end
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (load) hold_q <= w_data;
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign out_valid = busy_q;
  assign out_data  = (hold_q >> pos) & mask;

endmodule

// File: rtl/bm_bus_match.sv
module bm_bus_match #(
  parameter int unsigned WORD_W = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_in_size,
  input  logic [1:0]        cfg_out_size,
  input  logic              cfg_big_endian,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_ready,
  input  logic              word_in_valid,
  input  logic [WORD_W-1:0] word_in_data,
  output logic              word_in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_ready
);

  logic       rst_s;
  logic [1:0] in_sel_q, out_sel_q;
  logic       big_q;

  bm_rst_sync #(.STAGES(2)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .rst_s(rst_s)
  );

  // Configuration follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_s) begin
      in_sel_q  <= cfg_in_size;
      out_sel_q <= cfg_out_size;
      big_q     <= cfg_big_endian;
    end
  end

  bm_packer #(.WORD_W(WORD_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_s),
    .sel     (in_sel_q),
    .in_valid(in_valid),
    .in_data (in_data),
    .in_ready(in_ready),
    .w_valid (word_valid),
    .w_data  (word_data),
    .w_ready (word_ready)
  );

  bm_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_s),
    .sel      (out_sel_q),
    .big      (big_q),
    .w_valid  (word_in_valid),
    .w_data   (word_in_data),
    .w_ready  (word_in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ready(out_ready)
  );

endmodule

// File: rtl/bm_bus_match_chk.sv
module bm_bus_match_chk #(
  parameter int unsigned WORD_W = 80
) (
  input logic              clk,
  input logic              rst_s,
  input logic [1:0]        out_sel,
  input logic              in_ready,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              word_ready,
  input logic              word_in_ready,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_data,
  input logic              out_ready
);

  // R9: held packed word stays put while stalled
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  // R9: stalled piece stays put
  p_piece_hold_r9: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: packer refuses input while its word is stuck
  p_pack_block_r9: assert property (@(posedge clk) disable iff (!rst_s)
    word_valid && !word_ready |-> !in_ready);

  // R9: unpacker refuses a new word while a piece is stalled
  p_unpack_block_r9: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid && !out_ready |-> !word_in_ready);

  // R4: bits above the piece width are zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> ((out_data >> (WORD_W >> out_sel)) == '0));

endmodule

bind bm_bus_match bm_bus_match_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst_s        (rst_s),
  .out_sel      (out_sel_q),
  .in_ready     (in_ready),
  .word_valid   (word_valid),
  .word_data    (word_data),
  .word_ready   (word_ready),
  .word_in_ready(word_in_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_ready    (out_ready)
);

// File: tb/bm_bus_match_bench.sv
module bm_bus_match_bench;

  localparam int W = 80;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   cfg_in_size, cfg_out_size;
  logic         cfg_big_endian;
  logic         in_valid;
  logic [W-1:0] in_data;
  logic         in_ready;
  logic         lb_valid, lb_ready;
  logic [W-1:0] lb_data;
  logic         out_valid, out_ready;
  logic [W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] words [64];
  logic [W-1:0] outs  [64];
  int n_word = 0;
  int n_out  = 0;

  always #10 clk = ~clk;

  bm_bus_match #(.WORD_W(W)) u_bm_bus_match (
    .clk(clk), .rst_n(rst_n),
    .cfg_in_size(cfg_in_size), .cfg_out_size(cfg_out_size), .cfg_big_endian(cfg_big_endian),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .word_valid(lb_valid), .word_data(lb_data), .word_ready(lb_ready),
    .word_in_valid(lb_valid), .word_in_data(lb_data), .word_in_ready(lb_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // Monitor: records transfers that complete at the following rising edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_word = 0;
      n_out  = 0;
    end else begin
      if (lb_valid && lb_ready && n_word < 64) begin words[n_word] = lb_data; n_word++; end
      if (out_valid && out_ready && n_out < 64) begin outs[n_out] = out_data; n_out++; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lanemask(input logic [1:0] code);
    return {W{1'b1}} >> (W - (W >> code));
  endfunction

  task automatic do_reset(input logic [1:0] si, input logic [1:0] so, input logic big);
    @(negedge clk);
    rst_n = 1'b0; cfg_in_size = si; cfg_out_size = so; cfg_big_endian = big;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Sends the first 'count' pieces of word w; upper lane bits carry ones (ignored)
  task automatic send(input logic [W-1:0] w, input logic [1:0] si, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = ((w >> (k * (W >> si))) & lanemask(si)) | ~lanemask(si);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] exp_piece(input logic [W-1:0] w, input logic [1:0] so,
                                             input logic big, input int k);
    int n;
    int slot;
    n    = 1 << so;
    slot = big ? (n - 1 - k) : k;
    return (w >> (slot * (W >> so))) & lanemask(so);
  endfunction

  // Table: [84:83] input code, [82:81] output code, [80] big-endian, [79:0] word
  localparam logic [84:0] VEC [7] = '{
    {2'd0, 2'd0, 1'b0, 80'h0123_4567_89AB_CDEF_F00D},
    {2'd1, 2'd2, 1'b1, 80'hDEAD_BEEF_CAFE_1234_5678},
    {2'd3, 2'd3, 1'b0, 80'h3FF_2AB_155_0C3_F0F1_2345},
    {2'd3, 2'd3, 1'b1, 80'h3FF_2AB_155_0C3_F0F1_2345},
    {2'd2, 2'd1, 1'b1, 80'hA5A5_5A5A_0F0F_F0F0_1357},
    {2'd0, 2'd3, 1'b1, 80'h8001_4002_2004_1008_0810},
    {2'd1, 2'd0, 1'b0, 80'hFFFF_0000_FFFF_0000_ABCD}
  };

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    cfg_in_size = 2'd0; cfg_out_size = 2'd0; cfg_big_endian = 1'b0;

    // R10: reset state
    do_reset(2'd0, 2'd0, 1'b0);
    chk(in_ready == 1'b1, "R10 in_ready", W'(in_ready), W'(1));
    chk(lb_valid == 1'b0, "R10 word_valid", W'(lb_valid), W'(0));
    chk(out_valid == 1'b0, "R10 out_valid", W'(out_valid), W'(0));
    chk(lb_ready == 1'b1, "R10 word_in_ready", W'(lb_ready), W'(1));

    // Table walk: R1 counts, R2/R3 packing, R4/R5/R6 unpacking order
    foreach (VEC[i]) begin
      logic [1:0] si, so;
      logic big;
      logic [W-1:0] w;
      si = VEC[i][84:83]; so = VEC[i][82:81]; big = VEC[i][80]; w = VEC[i][79:0];
      do_reset(si, so, big);
      send(w, si, 1 << si);
      repeat (12) @(negedge clk);
      chk(n_word == 1, "R3 one word", W'(n_word), W'(1));
      chk(words[0] == w, "R2 packed word", words[0], w);
      chk(n_out == (1 << so), "R1 piece count", W'(n_out), W'(1 << so));
      for (int k = 0; k < (1 << so); k++)
        chk(outs[k] == exp_piece(w, so, big, k), big ? "R6 big order" : "R5 little order",
            outs[k], exp_piece(w, so, big, k));
    end

    // R3: no partial word after 3 of 4 pieces
    do_reset(2'd2, 2'd0, 1'b0);
    send(80'h1111_2222_3333_4444_5555, 2'd2, 3);
    repeat (4) @(negedge clk);
    chk(n_word == 0 && lb_valid == 1'b0, "R3 partial held", W'(n_word), W'(0));

    // R8: reset mid-pack discards, next word starts at piece 0
    do_reset(2'd3, 2'd3, 1'b0);
    send(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 2'd3, 3);
    do_reset(2'd3, 2'd3, 1'b0);
    send(80'h0246_8ACE_1357_9BDF_0011, 2'd3, 8);
    repeat (12) @(negedge clk);
    chk(n_word == 1, "R8 word count after reset", W'(n_word), W'(1));
    chk(words[0] == 80'h0246_8ACE_1357_9BDF_0011, "R8 clean word", words[0], 80'h0246_8ACE_1357_9BDF_0011);

    // R8: reset mid-unpack discards the remaining pieces
    do_reset(2'd0, 2'd3, 1'b0);
    @(posedge clk); #1 out_ready = 1'b0;
    send(80'h9999_8888_7777_6666_5555, 2'd0, 1);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R8 unpack loaded", W'(out_valid), W'(1));
    do_reset(2'd0, 2'd3, 1'b0);
    chk(out_valid == 1'b0, "R8 unpack flushed", W'(out_valid), W'(0));
    @(posedge clk); #1 out_ready = 1'b1;
    send(80'h0000_0000_0000_0000_03C5, 2'd0, 1);
    repeat (12) @(negedge clk);
    chk(n_out == 8 && outs[0] == 80'h3C5, "R8 first piece restarts", outs[0], 80'h3C5);

    // R7: config pins moved after reset are ignored
    do_reset(2'd1, 2'd0, 1'b0);
    cfg_in_size = 2'd3; cfg_out_size = 2'd3; cfg_big_endian = 1'b1;
    send(80'hC0FF_EE00_1234_5678_9ABC, 2'd1, 2);
    repeat (6) @(negedge clk);
    chk(n_word == 1, "R7 input width kept", W'(n_word), W'(1));
    chk(n_out == 1 && outs[0] == 80'hC0FF_EE00_1234_5678_9ABC, "R7 output width kept",
        outs[0], 80'hC0FF_EE00_1234_5678_9ABC);

    // R9: stall backs up into the packer, data stays stable
    do_reset(2'd0, 2'd3, 1'b0);
    @(posedge clk); #1 out_ready = 1'b0;
    send(80'h1357_9BDF_2468_ACE0_1122, 2'd0, 1);
    send(80'h3344_5566_7788_99AA_BBCC, 2'd0, 1);
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R9 input blocked", W'(in_ready), W'(0));
    chk(out_data == 80'h122, "R9 piece held", out_data, 80'h122);
    repeat (3) @(negedge clk);
    chk(out_data == 80'h122 && out_valid, "R9 piece stable", out_data, 80'h122);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (24) @(negedge clk);
    chk(n_out == 16, "R9 all pieces drained", W'(n_out), W'(16));
    for (int k = 0; k < 8; k++)
      chk(outs[8 + k] == exp_piece(80'h3344_5566_7788_99AA_BBCC, 2'd3, 1'b0, k), "R9 second word",
          outs[8 + k], exp_piece(80'h3344_5566_7788_99AA_BBCC, 2'd3, 1'b0, k));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule